// File: doc/BRIEF.md
# Dual Four-Mode Timer/Counter

This block holds two timer/counter channels. Each channel keeps a 16-bit count as a low byte and a high byte. It advances either on an internal machine-cycle tick or on falling edges of an external count pin. The machine cycle is a fixed number of clock periods, twelve by default. A mode register sets up each channel: its count mode, its count source and whether a level on a gate pin qualifies counting. Gating is how the block measures the width of a pulse. A control register holds the two run bits and the two sticky overflow flags.

There are four count modes. The first is a 13-bit count: a 5-bit prescaler sits in the low byte and feeds the high byte. The second is a plain 16-bit count. The third is an 8-bit count that reloads from the high byte when it overflows. The fourth is a split mode. In split mode channel 0 becomes two independent 8-bit counters, and its high half takes over channel 1's run bit and overflow flag. Every overflow of channel 1 also gives a one-clock pulse, which a baud-rate generator can use. Software writes the registers through a simple address/data write port, and the counts and flags come straight out as outputs.

Top module: `dual_tmr_core`

## Requirements
- R1: A machine tick occurs once every OSC_DIV (12) clock cycles, and the first tick falls on the 12th rising edge after reset is released. In timer function an enabled channel advances by exactly one on each tick.
- R2: In counter function (mode nibble bit 2 = 1) the count pin is sampled on every tick. The channel advances on a tick whose sample is low when the sample on the previous tick was high. A steady level never counts.
- R3: A channel is enabled when its run bit is 1 and, if its gate-enable bit (mode nibble bit 3) is 1, its gate pin is also high. With gate-enable at 0 the gate pin has no effect.
- R4: Mode 1 (nibble bits [1:0] = 1) counts over the full 16 bits. The rollover from 0xFFFF to 0x0000 sets the channel's overflow flag.
- R5: Mode 0 counts 13 bits, made of the high byte and low-byte bits [4:0]. Low-byte bits [7:5] are never changed by counting. The rollover of all 13 bits to zero sets the flag.
- R6: Mode 2 advances the low byte only. On a count from 0xFF the low byte loads the high byte and the flag is set.
- R7: With channel 0 in mode 3, the channel 0 low byte counts under channel 0's own run, gate and source settings, and its rollover sets flag 0. The channel 0 high byte counts ticks while run bit 1 is set, and its rollover sets flag 1.
- R8: Channel 1 in mode 3 holds its count. While channel 0 is in mode 3, channel 1 counts in its own mode 0–2 regardless of run bit 1, and its overflows never set flag 1.
- R9: `baud_pulse` is high for exactly one clock, on the clock after each channel 1 overflow, in every mode combination.
- R10: A write to a count byte in the same cycle as a count loads the written value and suppresses that count. A control write in the same cycle as an overflow takes the written flag value.
- R11: Overflow flags stay set until software writes the control register with the flag bit at 0.
- R12: After reset, both counts, both flags and `baud_pulse` are 0 and both channels are stopped.
- R13: Write addresses are 0 = mode register (channel 0 in bits [3:0], channel 1 in bits [7:4]), 1 = control (bit 0 run 0, bit 1 run 1, bit 2 flag 0, bit 3 flag 1), 2/3 = channel 0 low/high byte, and 4/5 = channel 1 low/high byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select (see R13) |
| wr_data | input | 8 | Write data |
| cnt_pin | input | 2 | External count inputs, one per channel, synchronous to clk |
| gate_pin | input | 2 | Gate level inputs, one per channel |
| t0_count | output | 16 | Channel 0 count {high byte, low byte} |
| t1_count | output | 16 | Channel 1 count {high byte, low byte} |
| ovf_flag | output | 2 | Overflow flags, bit i for channel i |
| baud_pulse | output | 1 | One-clock pulse after each channel 1 overflow |

## Verification
Counts and flags change on the rising edge that carries a tick, so any window of 12·n clocks contains exactly n ticks whatever its phase. The bench also keeps its own tick count from reset and measures each expected value against a baseline taken just after the relevant write or pin change. The baud pulse follows the overflow edge by one clock, and a negedge monitor tallies it against the number of overflows worked out arithmetically. Pin patterns and same-cycle writes are lined up to the bench's tick count, so a sample or a collision lands on a known edge.

// File: rtl/tmr_pkg.sv
// Shared types for the dual timer/counter.
// Assumes a mode nibble of {gate enable, counter select, mode[1:0]}.
package tmr_pkg;
    typedef enum logic [1:0] {
        TM_PRESC13 = 2'd0,
        TM_FULL16  = 2'd1,
        TM_RELOAD8 = 2'd2,
        TM_SPLIT   = 2'd3
    } tmr_mode_e;

    typedef struct packed {
        logic      gate_en;
        logic      ctr_sel;
        tmr_mode_e mode;
    } chan_cfg_t;

    localparam int CFG_W = $bits(chan_cfg_t);

    localparam logic [2:0] ADDR_MODE = 3'd0;
    localparam logic [2:0] ADDR_CTRL = 3'd1;
    localparam logic [2:0] ADDR_T0L  = 3'd2;
    localparam logic [2:0] ADDR_T0H  = 3'd3;
    localparam logic [2:0] ADDR_T1L  = 3'd4;
    localparam logic [2:0] ADDR_T1H  = 3'd5;
endpackage

// File: rtl/tmr_tick_gen.sv
// Machine-cycle tick generator: a one-clock strobe every DIV clocks.
// Assumes DIV >= 1; the phase restarts at zero on reset.
module tmr_tick_gen #(
    parameter int DIV = 12
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] phase;

    // Phase counter wrapping at DIV-1.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase <= '0;
        else if (phase == LAST)
            phase <= '0;
        else
            phase <= phase + 1'b1;
    end

    assign tick = (phase == LAST);

    generate
        if (DIV > 1) begin : g_chk
            a_r1_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/tmr_src.sv
// Count-event qualifier for one channel: picks the tick or a sampled falling
// edge of the count pin, and applies the run bit and optional gate level.
// Assumes pin and gate are synchronous to clk.
module tmr_src (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic pin,
    input  logic gate_pin,
    input  logic run,
    input  logic gate_en,
    input  logic ctr_sel,
    output logic inc
);
    logic s_last;
    logic fall;
    logic allow;

    // Keep the pin sample of the previous machine tick.
    always_ff @(posedge clk) begin
        if (!rst_n)
            s_last <= 1'b0;
        else if (tick)
            s_last <= pin;
    end

    // Edge detect and enable qualification.
    always_comb begin
        fall  = s_last & ~pin;
        allow = run & (~gate_en | gate_pin);
        inc   = tick & allow & (ctr_sel ? fall : 1'b1);
    end

    a_r3_blocked_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_en && !gate_pin) |-> !inc);
    a_r2_steady_pin: assert property (@(posedge clk) disable iff (!rst_n)
        (ctr_sel && tick && $past(tick, 12) && $stable(pin) && $past(pin) == pin
         && $past(s_last) == pin) |-> !inc);
endmodule

// File: rtl/tmr_chan.sv
// One 16-bit timer channel held as two bytes, with the four count modes.
// SPLIT selects whether the high byte may run as an independent 8-bit timer
// in mode 3; without it, mode 3 holds the count. Byte writes win over counts.
module tmr_chan
    import tmr_pkg::*;
#(
    parameter int BW    = 8,
    parameter int PW    = 5,
    parameter bit SPLIT = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  tmr_mode_e     mode,
    input  logic          inc_lo,
    input  logic          inc_hi,
    input  logic          wr_lo,
    input  logic          wr_hi,
    input  logic [BW-1:0] wdata,
    output logic [BW-1:0] lo,
    output logic [BW-1:0] hi,
    output logic          ovf,
    output logic          ovf_hi
);
    logic [BW-1:0] nlo;
    logic [BW-1:0] nhi;
    logic          split_ok;

    generate
        if (SPLIT) begin : g_split
            assign split_ok = 1'b1;
        end else begin : g_nosplit
            assign split_ok = 1'b0;
        end
    endgenerate

    // Next-count logic per mode, then write override.
    always_comb begin
        nlo    = lo;
        nhi    = hi;
        ovf    = 1'b0;
        ovf_hi = 1'b0;
        case (mode)
            TM_PRESC13: if (inc_lo) begin
                nlo[PW-1:0] = lo[PW-1:0] + 1'b1;
                if (&lo[PW-1:0]) begin
                    nhi = hi + 1'b1;
                    ovf = &hi;
                end
            end
            TM_FULL16: if (inc_lo) begin
                nlo = lo + 1'b1;
                if (&lo) begin
                    nhi = hi + 1'b1;
                    ovf = &hi;
                end
            end
            TM_RELOAD8: if (inc_lo) begin
                if (&lo) begin
                    nlo = hi;
                    ovf = 1'b1;
                end else begin
                    nlo = lo + 1'b1;
                end
            end
            default: if (split_ok) begin
                if (inc_lo) begin
                    nlo = lo + 1'b1;
                    ovf = &lo;
                end
                if (inc_hi) begin
                    nhi    = hi + 1'b1;
                    ovf_hi = &hi;
                end
            end
        endcase
        if (mode == TM_SPLIT) begin
            if (wr_lo) begin
                nlo = wdata;
                ovf = 1'b0;
            end
            if (wr_hi) begin
                nhi    = wdata;
                ovf_hi = 1'b0;
            end
        end else if (wr_lo || wr_hi) begin
            nlo = wr_lo ? wdata : lo;
            nhi = wr_hi ? wdata : hi;
            ovf = 1'b0;
        end
    end

    // Count registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo <= '0;
            hi <= '0;
        end else begin
            lo <= nlo;
            hi <= nhi;
        end
    end

    a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> lo == $past(wdata));
    a_r4_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc_lo && !inc_hi && !wr_lo && !wr_hi) |=> $stable({hi, lo}));
    a_r6_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == TM_RELOAD8 && inc_lo && &lo && !wr_lo && !wr_hi) |=> lo == $past(hi));
    a_r5_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == TM_PRESC13 && !wr_lo) |=> lo[BW-1:PW] == $past(lo[BW-1:PW]));
endmodule

// File: rtl/dual_tmr_core.sv
// Dual four-mode timer/counter. Holds the mode and control registers, makes
// the machine tick, routes run bits (including the split-mode hand-over of
// run 1 and flag 1 to channel 0's high byte) and registers the baud pulse.
// Assumes BYTE_W >= 8 so the mode register fits in one write.
module dual_tmr_core
    import tmr_pkg::*;
#(
    parameter int OSC_DIV = 12,
    parameter int BYTE_W  = 8,
    parameter int PRESC_W = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [2:0]          wr_addr,
    input  logic [BYTE_W-1:0]   wr_data,
    input  logic [1:0]          cnt_pin,
    input  logic [1:0]          gate_pin,
    output logic [2*BYTE_W-1:0] t0_count,
    output logic [2*BYTE_W-1:0] t1_count,
    output logic [1:0]          ovf_flag,
    output logic                baud_pulse
);
    localparam int NCH = 2;

    logic [NCH*CFG_W-1:0] mode_q;
    logic [NCH-1:0]       run_q;
    logic [NCH-1:0]       flag_q;
    logic                 baud_q;
    logic                 tick;
    chan_cfg_t            cfg [NCH];
    logic [NCH-1:0]       run_eff;
    logic [NCH-1:0]       inc;
    logic                 t0_split;
    logic                 wr_ctrl;
    logic [NCH-1:0]       wr_lo;
    logic [NCH-1:0]       wr_hi;
    logic [NCH-1:0]       ovf;
    logic [NCH-1:0]       ovf_hi;
    logic [BYTE_W-1:0]    lo_q [NCH];
    logic [BYTE_W-1:0]    hi_q [NCH];
    logic                 split_hi_inc;
    logic                 flag1_set;

    tmr_tick_gen #(.DIV(OSC_DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    // Write decode and split-mode routing.
    always_comb begin
        wr_ctrl      = wr_en && (wr_addr == ADDR_CTRL);
        wr_lo[0]     = wr_en && (wr_addr == ADDR_T0L);
        wr_hi[0]     = wr_en && (wr_addr == ADDR_T0H);
        wr_lo[1]     = wr_en && (wr_addr == ADDR_T1L);
        wr_hi[1]     = wr_en && (wr_addr == ADDR_T1H);
        t0_split     = (cfg[0].mode == TM_SPLIT);
        run_eff[0]   = run_q[0];
        run_eff[1]   = t0_split ? 1'b1 : run_q[1];
        split_hi_inc = tick && run_q[1] && t0_split;
        flag1_set    = t0_split ? ovf_hi[0] : ovf[1];
    end

    generate
        for (genvar i = 0; i < NCH; i++) begin : g_ch
            assign cfg[i] = chan_cfg_t'(mode_q[i*CFG_W +: CFG_W]);

            tmr_src u_src (
                .clk     (clk),
                .rst_n   (rst_n),
                .tick    (tick),
                .pin     (cnt_pin[i]),
                .gate_pin(gate_pin[i]),
                .run     (run_eff[i]),
                .gate_en (cfg[i].gate_en),
                .ctr_sel (cfg[i].ctr_sel),
                .inc     (inc[i])
            );

            tmr_chan #(
                .BW   (BYTE_W),
                .PW   (PRESC_W),
                .SPLIT(i == 0)
            ) u_chan (
                .clk   (clk),
                .rst_n (rst_n),
                .mode  (cfg[i].mode),
                .inc_lo(inc[i]),
                .inc_hi((i == 0) ? split_hi_inc : 1'b0),
                .wr_lo (wr_lo[i]),
                .wr_hi (wr_hi[i]),
                .wdata (wr_data),
                .lo    (lo_q[i]),
                .hi    (hi_q[i]),
                .ovf   (ovf[i]),
                .ovf_hi(ovf_hi[i])
            );
        end
    endgenerate

    // Mode register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= '0;
        else if (wr_en && wr_addr == ADDR_MODE)
            mode_q <= wr_data[NCH*CFG_W-1:0];
    end

    // Control register: run bits and sticky flags, writes first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= '0;
            flag_q <= '0;
        end else if (wr_ctrl) begin
            run_q  <= wr_data[1:0];
            flag_q <= wr_data[3:2];
        end else begin
            if (ovf[0])
                flag_q[0] <= 1'b1;
            if (flag1_set)
                flag_q[1] <= 1'b1;
        end
    end

    // Baud pulse follows each channel 1 overflow by one clock.
    always_ff @(posedge clk) begin
        if (!rst_n)
            baud_q <= 1'b0;
        else
            baud_q <= ovf[1];
    end

    assign t0_count   = {hi_q[0], lo_q[0]};
    assign t1_count   = {hi_q[1], lo_q[1]};
    assign ovf_flag   = flag_q;
    assign baud_pulse = baud_q;

    a_r8_split_no_flag1: assert property (@(posedge clk) disable iff (!rst_n)
        (t0_split && ovf[1] && !ovf_hi[0] && !flag_q[1] && !wr_ctrl) |=> !flag_q[1]);
    a_r11_flag0_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q[0] && !wr_ctrl) |=> flag_q[0]);
    a_r11_flag1_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q[1] && !wr_ctrl) |=> flag_q[1]);
    a_r9_baud_follows: assert property (@(posedge clk) disable iff (!rst_n)
        ovf[1] |=> baud_pulse);

    generate
        if (OSC_DIV > 1) begin : g_baud_chk
            a_r9_baud_single: assert property (@(posedge clk) disable iff (!rst_n)
                baud_pulse |=> !baud_pulse);
        end
    endgenerate
endmodule

// File: tb/sim_dual_tmr_core.sv
module sim_dual_tmr_core;
    localparam logic [2:0] A_MODE = 3'd0, A_CTRL = 3'd1, A_T0L = 3'd2,
                           A_T0H = 3'd3, A_T1L = 3'd4, A_T1H = 3'd5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [1:0]  cnt_pin = '0;
    logic [1:0]  gate_pin = '0;
    logic [15:0] t0_count, t1_count;
    logic [1:0]  ovf_flag;
    logic        baud_pulse;

    int n_chk = 0, n_fail = 0;
    int edges = 0, ticks = 0, baud_n = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dual_tmr_core u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .cnt_pin(cnt_pin), .gate_pin(gate_pin),
        .t0_count(t0_count), .t1_count(t1_count), .ovf_flag(ovf_flag),
        .baud_pulse(baud_pulse)
    );

    // Bench-side tick model: a tick on every 12th edge after reset release.
    always @(posedge clk) begin
        if (!rst_n) begin
            edges <= 0;
            ticks <= 0;
        end else begin
            edges <= edges + 1;
            if ((edges + 1) % 12 == 0) ticks <= ticks + 1;
        end
    end

    always @(negedge clk) if (rst_n && baud_pulse) baud_n++;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0; cnt_pin = '0; gate_pin = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        baud_n = 0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic mc(input int n);
        repeat (12 * n) @(negedge clk);
    endtask

    task automatic align();
        while (edges % 12 != 0) @(negedge clk);
    endtask

    task automatic wr_at_tick(input logic [2:0] a, input logic [7:0] d);
        while ((edges + 1) % 12 != 0) @(negedge clk);
        wr(a, d);
    endtask

    initial begin
        int base;
        logic [15:0] v;
        logic [15:0] pat;
        int exp_c;
        logic [12:0] v13;
        logic [7:0] l8;
        int ov;

        // R12: reset state
        do_reset();
        chk("R12 t0 reset", t0_count, 0);
        chk("R12 t1 reset", t1_count, 0);
        chk("R12 flags reset", ovf_flag, 0);
        chk("R12 baud reset", baud_pulse, 0);
        mc(2);
        chk("R12 stopped after reset", t0_count, 0);

        // R4/R1/R13: 16-bit mode sweep through rollover
        wr(A_MODE, 8'h01);
        wr(A_T0L, 8'hF0);
        wr(A_T0H, 8'hFF);
        wr(A_CTRL, 8'h01);
        for (int k = 1; k <= 20; k++) begin
            mc(1);
            v = 16'hFFF0 + 16'(k);
            chk("R4 count16", t0_count, v);
            chk("R4 flag0", ovf_flag[0], (k >= 16));
        end
        chk("R13 t1 untouched", t1_count, 0);
        // R1: exactly 12 clocks per increment
        align();
        v = t0_count;
        repeat (11) @(negedge clk);
        chk("R1 no early step", t0_count, v);
        @(negedge clk);
        chk("R1 step on 12th clock", t0_count, v + 16'd1);
        // R11: flag persists, then clears on write 0
        mc(3);
        chk("R11 flag sticky", ovf_flag[0], 1);
        wr(A_CTRL, 8'h01);
        chk("R11 flag cleared", ovf_flag[0], 0);

        // R5: 13-bit prescaled mode
        do_reset();
        wr(A_MODE, 8'h00);
        wr(A_T0L, 8'hBC);
        wr(A_T0H, 8'hFF);
        wr(A_CTRL, 8'h01);
        for (int k = 1; k <= 6; k++) begin
            mc(1);
            v13 = {8'hFF, 5'd28} + 13'(k);
            chk("R5 count13", t0_count, {v13[12:5], 3'b101, v13[4:0]});
            chk("R5 flag0", ovf_flag[0], (k >= 4));
        end

        // R6/R9: auto-reload on channel 1, baud pulse tally
        do_reset();
        wr(A_MODE, 8'h20);
        wr(A_T1H, 8'hF0);
        wr(A_T1L, 8'hFD);
        wr(A_CTRL, 8'h02);
        for (int k = 1; k <= 40; k++) begin
            mc(1);
            l8 = (k < 3) ? 8'(8'hFD + k) : 8'(8'hF0 + (k - 3) % 16);
            ov = (k < 3) ? 0 : 1 + (k - 3) / 16;
            chk("R6 reload count", t1_count, {8'hF0, l8});
            chk("R9 baud pulses", baud_n, ov);
        end
        chk("R6 flag1", ovf_flag[1], 1);

        // R3: gating
        do_reset();
        wr(A_MODE, 8'h09);
        wr(A_CTRL, 8'h01);
        mc(5);
        chk("R3 gate low holds", t0_count, 0);
        gate_pin[0] = 1'b1;
        base = ticks;
        mc(7);
        chk("R3 gate high counts", t0_count, 16'(ticks - base));
        v = t0_count;
        wr(A_CTRL, 8'h00);
        v = v + 16'(ticks - base - 16'(v));
        mc(3);
        chk("R3 run off holds", t0_count, v);
        gate_pin[0] = 1'b0;
        wr(A_MODE, 8'h01);
        wr(A_CTRL, 8'h01);
        base = ticks;
        v = t0_count;
        mc(4);
        chk("R3 gate ignored when disabled", t0_count, v + 16'(ticks - base));

        // R2: counter function with a pin pattern, one bit per machine cycle
        do_reset();
        wr(A_MODE, 8'h05);
        wr(A_CTRL, 8'h01);
        align();
        pat = 16'b1011_0010_1110_0110;
        exp_c = 0;
        for (int i = 0; i < 16; i++) begin
            if (i > 0 && pat[i-1] && !pat[i]) exp_c++;
            cnt_pin[0] = pat[i];
            mc(1);
            chk("R2 edge count", t0_count, exp_c);
        end
        cnt_pin[0] = 1'b1;
        mc(4);
        chk("R2 steady high", t0_count, exp_c);

        // R7/R8: split mode
        do_reset();
        wr(A_MODE, 8'h13);
        wr(A_T0L, 8'hFE);
        wr(A_T0H, 8'hFD);
        wr(A_T1L, 8'hFE);
        wr(A_T1H, 8'hFF);
        wr(A_CTRL, 8'h01);
        mc(2);
        chk("R7 low byte rollover", t0_count, 16'hFD00);
        chk("R7 flag0 from low", ovf_flag[0], 1);
        chk("R8 t1 runs without run1", t1_count, 16'h0000);
        chk("R8 no flag1 from t1", ovf_flag[1], 0);
        chk("R8 baud still pulses", baud_n, 1);
        wr(A_CTRL, 8'h02);
        mc(3);
        chk("R7 high byte on run1", t0_count, 16'h0000);
        chk("R7 flag1 from high", ovf_flag[1], 1);
        chk("R7 flag0 cleared", ovf_flag[0], 0);
        chk("R8 t1 continues", t1_count, 16'h0003);

        // R8: channel 1 in mode 3 holds
        do_reset();
        wr(A_MODE, 8'h31);
        wr(A_T1L, 8'h12);
        wr(A_CTRL, 8'h03);
        mc(4);
        chk("R8 t1 mode3 holds", t1_count, 16'h0012);
        chk("R8 t0 runs", t0_count, 16'h0004);

        // R10: write beats a same-cycle count
        do_reset();
        wr(A_MODE, 8'h01);
        wr(A_T0L, 8'h40);
        wr(A_CTRL, 8'h01);
        wr_at_tick(A_T0L, 8'h55);
        chk("R10 byte write wins", t0_count, 16'h0055);
        mc(1);
        chk("R10 counts after write", t0_count, 16'h0056);
        wr(A_CTRL, 8'h00);
        wr(A_T0L, 8'hFF);
        wr(A_T0H, 8'hFF);
        wr(A_CTRL, 8'h01);
        wr_at_tick(A_CTRL, 8'h01);
        chk("R10 count wraps", t0_count, 16'h0000);
        chk("R10 ctrl write beats flag", ovf_flag[0], 0);
        mc(1);
        chk("R10 resumes", t0_count, 16'h0001);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule